// File: doc/BRIEF.md
# Packed Multiply-Add and Sum-of-Absolute-Differences Unit

This block is a vector datapath with two horizontal-reduction functions behind one 128-bit operand interface. In the multiply-add function each operand holds eight signed 16-bit elements. Matching elements are multiplied, and each adjacent pair of products is added into one signed 32-bit result element. In the difference-sum function each operand holds sixteen unsigned bytes. The absolute byte differences are added up separately for each 64-bit half.

A one-cycle strobe `go` captures both operands and the function select. One clock later `fin` pulses once, and the result stays on `res` until the next strobe has been processed. Element 0 always sits in the least significant bits of every bus.

Top module: `vec_reduce_unit`

## Requirements
- R1: With `op_sad`=0 (multiply-add), 32-bit result element i (bits 32i+31..32i) equals a[2i]*b[2i] + a[2i+1]*b[2i+1]. Each a[k] and b[k] is the signed 16-bit element at bits 16k+15..16k, and each product is formed signed to 32 bits.
- R2: The multiply-add pair sum wraps modulo 2^32. Two products of -32768 * -32768 give 0x80000000.
- R3: With `op_sad`=1, bits 15..0 of the result hold the sum of |a[k]-b[k]| over unsigned bytes k=0..7, where byte k is at bits 8k+7..8k. Bits 79..64 hold the same sum over bytes 8..15.
- R4: In difference-sum mode, result bits 63..16 and 127..80 are zero.
- R5: `fin` is high for exactly the one cycle after a cycle with `go` high, and is low otherwise.
- R6: `res` changes only on the cycle after a `go`. It keeps its value while `go` is low, whatever `a`, `b` or `op_sad` do.
- R7: A synchronous active-high `rst` clears `res` to zero and `fin` to 0. Back-to-back `go` strobes each produce a result and a `fin` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Capture strobe for operands and function select |
| op_sad | input | 1 | 0 = multiply-add, 1 = sum of absolute differences |
| a | input | 128 | First operand vector |
| b | input | 128 | Second operand vector |
| res | output | 128 | Registered result vector |
| fin | output | 1 | One-cycle result-valid pulse |

## Verification
A strobe can arrive in the same cycle that the result of the previous strobe is being presented. When that happens, capture and output update overlap. The bench provokes this with back-to-back strobes that alternate between the two functions. In the cycle after each strobe it checks that `res` holds the new function's value. It also checks that `fin` stays high across the run of strobes and drops one cycle after the last one.

// File: rtl/vru_pkg.sv
package vru_pkg;
  parameter int VW = 128;
  localparam int MW = 16;
  localparam int ML = VW / MW;
  localparam int PL = ML / 2;
  localparam int BL = VW / 8;
  localparam int HL = 2;
  localparam int BPH = BL / HL;
  localparam int SW = 16;
  typedef enum logic {FN_MAC = 1'b0, FN_SAD = 1'b1} fn_e;
endpackage

// File: rtl/vru_mac.sv
module vru_mac
  import vru_pkg::*;
#(
  parameter int W = VW
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  localparam int NP = W / 32;
  for (genvar i = 0; i < NP; i++) begin : g_pair
    logic signed [15:0] x0, x1, y0, y1;
    logic signed [31:0] p0, p1;
    assign x0 = x[32*i +: 16];
    assign x1 = x[32*i+16 +: 16];
    assign y0 = y[32*i +: 16];
    assign y1 = y[32*i+16 +: 16];
    assign p0 = x0 * y0;
    assign p1 = x1 * y1;
    assign z[32*i +: 32] = p0 + p1;
  end
endmodule

// File: rtl/vru_sad.sv
module vru_sad
  import vru_pkg::*;
#(
  parameter int W = VW
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  localparam int NH = 2;
  localparam int HB = W / 8 / NH;
  localparam int HW = W / NH;
  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [HB-1:0][7:0] d;
    logic [SW-1:0] acc;
    for (genvar k = 0; k < HB; k++) begin : g_byte
      logic [7:0] xb, yb;
      assign xb = x[(h*HB+k)*8 +: 8];
      assign yb = y[(h*HB+k)*8 +: 8];
      assign d[k] = (xb >= yb) ? (xb - yb) : (yb - xb);
    end
    always_comb begin
      acc = '0;
      for (int k = 0; k < HB; k++) acc = acc + SW'(d[k]);
    end
    assign z[h*HW +: HW] = {{(HW-SW){1'b0}}, acc};
  end
endmodule

// File: rtl/vec_reduce_unit.sv
module vec_reduce_unit
  import vru_pkg::*;
#(
  parameter int W = VW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         op_sad,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         fin
);
  logic [W-1:0] mac_z, sad_z;

  vru_mac #(.W(W)) u_mac (.x(a), .y(b), .z(mac_z));
  vru_sad #(.W(W)) u_sad (.x(a), .y(b), .z(sad_z));

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      fin <= 1'b0;
    end else begin
      fin <= go;
      if (go) res <= (fn_e'(op_sad) == FN_SAD) ? sad_z : mac_z;
    end
  end

  AST_FIN_FOLLOWS_GO: assert property (@(posedge clk) disable iff (rst) go |=> fin); // R5
  AST_FIN_ONLY_AFTER_GO: assert property (@(posedge clk) disable iff (rst) !go |=> !fin); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst) !go |=> $stable(res)); // R6
  AST_SAD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (go && op_sad) |=> (res[63:16] == '0 && res[127:80] == '0)); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (res == '0 && !fin)); // R7
endmodule

// File: tb/tb_vec_reduce_unit.sv
module tb_vec_reduce_unit;
  logic clk = 0, rst = 1, go = 0, op_sad = 0;
  logic [127:0] a = '0, b = '0;
  logic [127:0] res;
  logic fin;
  int errs = 0, checks = 0;
  logic [127:0] seed = 128'h0123456789abcdef_fedcba9876543210;

  always #10 clk = ~clk;

  vec_reduce_unit dut (.clk(clk), .rst(rst), .go(go), .op_sad(op_sad),
                       .a(a), .b(b), .res(res), .fin(fin));

  function automatic logic [127:0] mac_ref(logic [127:0] x, logic [127:0] y);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      longint s;
      s = longint'($signed(x[32*i +: 16])) * longint'($signed(y[32*i +: 16]))
        + longint'($signed(x[32*i+16 +: 16])) * longint'($signed(y[32*i+16 +: 16]));
      r[32*i +: 32] = s[31:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] sad_ref(logic [127:0] x, logic [127:0] y);
    logic [127:0] r = '0;
    for (int h = 0; h < 2; h++) begin
      int s = 0;
      for (int k = 0; k < 8; k++) begin
        int p = int'(x[(h*8+k)*8 +: 8]);
        int q = int'(y[(h*8+k)*8 +: 8]);
        s += (p > q) ? p - q : q - p;
      end
      r[64*h +: 16] = s[15:0];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] nxt(logic [127:0] s);
    return {s[126:0], s[127] ^ s[125] ^ s[100] ^ s[98]} ^ (s >> 7);
  endfunction

  task automatic run(logic m, logic [127:0] x, logic [127:0] y, string req);
    @(negedge clk); go = 1; op_sad = m; a = x; b = y;
    @(negedge clk); go = 0; a = ~x; b = y ^ 128'h5a;
    chk({req, " fin"}, {127'b0, fin}, 128'd1);
    chk(req, res, m ? sad_ref(x, y) : mac_ref(x, y));
  endtask

  initial begin
    #2000000; errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    chk("R7 reset res", res, '0);
    chk("R7 reset fin", {127'b0, fin}, '0);
    rst = 0;
    run(0, {8{16'h8000}}, {8{16'h8000}}, "R2");
    run(0, {8{16'h7fff}}, {8{16'h8000}}, "R1");
    run(0, {8{16'hffff}}, {8{16'h0003}}, "R1");
    run(1, {16{8'hff}}, '0, "R3");
    run(1, {{8{8'h00}}, {8{8'hff}}}, {{8{8'hff}}, {8{8'h00}}}, "R3");
    for (int i = 0; i < 40; i++) begin
      logic [127:0] x, y;
      seed = nxt(seed); x = seed;
      seed = nxt(seed); y = seed;
      run(i[0], x, y, i[0] ? "R3" : "R1");
      if (i[0]) chk("R4", res & ~{48'b0, 16'hffff, 48'b0, 16'hffff}, '0);
    end
    // hold while go low: R6, fin low: R5
    held = res;
    repeat (3) begin
      @(negedge clk); op_sad = ~op_sad; a = nxt(a);
      chk("R6 hold", res, held);
      chk("R5 fin low", {127'b0, fin}, '0);
    end
    // back-to-back: R7
    @(negedge clk); go = 1; op_sad = 0; a = {8{16'h0102}}; b = {8{16'h0003}};
    @(negedge clk); op_sad = 1;
    chk("R7 b2b mac", res, mac_ref({8{16'h0102}}, {8{16'h0003}}));
    chk("R7 b2b fin", {127'b0, fin}, 128'd1);
    @(negedge clk); go = 0;
    chk("R7 b2b sad", res, sad_ref({8{16'h0102}}, {8{16'h0003}}));
    chk("R7 b2b fin2", {127'b0, fin}, 128'd1);
    @(negedge clk);
    chk("R5 fin drop", {127'b0, fin}, '0);
    // reset mid-run
    rst = 1; @(negedge clk); rst = 0;
    chk("R7 reset again", res, '0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule